// File: doc/BRIEF.md
# Conflict-Aware Row Prefetch Decider

This block sits beside the command logic of one independent DRAM partition and decides, access by access, when a whole row should be copied into a nearby prefetch buffer. It watches the stream of accesses the partition has already serviced. Each access carries its bank, its row, and a flag that says whether it found that row already open. Accesses that the prefetch buffer already served are flagged too. The block then answers one cycle later. It can ask for a whole-row prefetch together with a precharge of the bank, or it can say that the newly opened row should stay open.

Two tables drive the decision. The first is a per-bank utilization table. It holds the row currently open in each bank and how often that row has been used. When a row is busy enough, it is copied out and the bank is closed. The second is a conflict history of rows that were recently closed because another row displaced them. It is shared by all banks, searched associatively on the combined bank and row tag, and kept in LRU order. A row that comes back soon after being displaced is treated as a conflict source and is prefetched at once.

Top module: `conflict_row_prefetcher`

## Requirements
- R1: After reset no output is asserted and both tables are empty, so the first miss on any bank only keeps its row open.
- R2: A miss whose bank and row are not in the conflict history sets keep_open, and clears pf_valid and pre_valid, one cycle after the access, with cmd_bank/cmd_row equal to the access.
- R3: A row opened by a miss counts as used once, and every later row hit adds one. The access that would take the count above THRESH (4 by default, so the fifth access) gives pf_valid and pre_valid one cycle later, with the bank and the open row. The accesses before it give nothing.
- R4: After a utilization prefetch, the bank's table entry is invalid. Later hits on that bank produce no output, and the prefetched row is not placed into the conflict history.
- R5: A miss on a bank with a valid open row places {bank,row} of that old row into the conflict history. A later miss that opens that same row in that same bank gives pf_valid and pre_valid with that bank and row, and keep_open stays low.
- R6: A conflict prefetch removes the matched entry, and the bank is left with no open row. Opening the same row again later is then an ordinary miss with keep_open.
- R7: The conflict history matches on bank and row together. A row closed in one bank does not trigger a prefetch when the same row number opens in another bank.
- R8: The conflict history holds CT_DEPTH (32) rows. When it is full, a new insertion replaces the entry that was inserted the longest time ago, and the other entries survive.
- R9: Accesses flagged as served by the prefetch buffer change neither table and produce no output.
- R10: Every output is a single-cycle response to one access. With no valid access in the previous cycle, pf_valid, pre_valid and keep_open are low.
- R11: A row hit on a bank with no valid table entry is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A serviced access is presented |
| acc_bank | input | BANK_W | Bank of the access |
| acc_row | input | ROW_W | Row of the access |
| acc_hit | input | 1 | The access found its row already open |
| acc_pfb | input | 1 | The access was served from the prefetch buffer |
| pf_valid | output | 1 | Copy the whole row cmd_bank/cmd_row into the prefetch buffer |
| pre_valid | output | 1 | Precharge bank cmd_bank |
| keep_open | output | 1 | Leave row cmd_row open in bank cmd_bank |
| cmd_bank | output | BANK_W | Bank that the response refers to |
| cmd_row | output | ROW_W | Row that the response refers to |

## Verification
The hardest case to reach from the ports is replacement in a full conflict history. Reaching it takes thirty-three displacements before a single eviction happens. The bench gets there by opening a chain of distinct rows in one bank, since each new row displaces the one before it. It then probes both the oldest row and the second-oldest row. Probing the first inserts one more entry, so the probe order is chosen so that this side effect cannot hide the row being checked.

// File: rtl/conflict_row_prefetcher.sv
module conflict_row_prefetcher #(
  parameter int BANKS    = 16,
  parameter int ROW_W    = 16,
  parameter int CT_DEPTH = 32,
  parameter int THRESH   = 4,
  localparam int BANK_W  = $clog2(BANKS),
  localparam int TAG_W   = BANK_W + ROW_W,
  localparam int AGE_W   = $clog2(CT_DEPTH),
  localparam int CNT_W   = $clog2(THRESH + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [BANK_W-1:0] acc_bank,
  input  logic [ROW_W-1:0]  acc_row,
  input  logic              acc_hit,
  input  logic              acc_pfb,
  output logic              pf_valid,
  output logic              pre_valid,
  output logic              keep_open,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row
);

  logic [BANKS-1:0]    rut_v;
  logic [ROW_W-1:0]    rut_row [BANKS];
  logic [CNT_W-1:0]    rut_cnt [BANKS];
  logic [CT_DEPTH-1:0] ct_v;
  logic [TAG_W-1:0]    ct_tag [CT_DEPTH];
  logic [AGE_W-1:0]    ct_age [CT_DEPTH];

  logic live, miss, old_v, hit_fire, conf_fire, ins;
  logic match, free;
  logic [AGE_W-1:0] match_idx, free_idx, lru_idx, ins_idx, ref_age, max_age;
  logic [TAG_W-1:0] new_tag, old_tag;

  assign live     = acc_valid && !acc_pfb;
  assign miss     = live && !acc_hit;
  assign old_v    = rut_v[acc_bank];
  assign new_tag  = {acc_bank, acc_row};
  assign old_tag  = {acc_bank, rut_row[acc_bank]};
  assign hit_fire = live && acc_hit && old_v && (rut_cnt[acc_bank] == CNT_W'(THRESH));

  always_comb begin
    match = 1'b0; match_idx = '0;
    free = 1'b0; free_idx = '0;
    lru_idx = '0; max_age = '0;
    for (int i = 0; i < CT_DEPTH; i++) begin
      if (ct_v[i] && ct_tag[i] == new_tag && !match) begin
        match = 1'b1; match_idx = AGE_W'(i);
      end
      if (!ct_v[i] && !free) begin
        free = 1'b1; free_idx = AGE_W'(i);
      end
      if (ct_v[i] && ct_age[i] >= max_age) begin
        max_age = ct_age[i]; lru_idx = AGE_W'(i);
      end
    end
  end

  assign conf_fire = miss && match;
  assign ins       = miss && old_v;
  assign ins_idx   = match ? match_idx : (free ? free_idx : lru_idx);
  assign ref_age   = ct_age[ins_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ct_v <= '0;
      for (int i = 0; i < CT_DEPTH; i++) begin
        ct_tag[i] <= '0;
        ct_age[i] <= '0;
      end
    end else if (ins) begin
      for (int i = 0; i < CT_DEPTH; i++) begin
        if (AGE_W'(i) == ins_idx) begin
          ct_v[i]   <= 1'b1;
          ct_tag[i] <= old_tag;
          ct_age[i] <= '0;
        end else if (ct_v[i] && (!ct_v[ins_idx] || ct_age[i] < ref_age)) begin
          ct_age[i] <= ct_age[i] + 1'b1;
        end
      end
    end else if (conf_fire) begin
      for (int i = 0; i < CT_DEPTH; i++) begin
        if (AGE_W'(i) == match_idx) ct_v[i] <= 1'b0;
        else if (ct_v[i] && ct_age[i] > ref_age) ct_age[i] <= ct_age[i] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rut_v <= '0;
      for (int b = 0; b < BANKS; b++) begin
        rut_row[b] <= '0;
        rut_cnt[b] <= '0;
      end
    end else if (hit_fire) begin
      rut_v[acc_bank] <= 1'b0;
    end else if (live && acc_hit && old_v) begin
      rut_cnt[acc_bank] <= rut_cnt[acc_bank] + 1'b1;
    end else if (miss) begin
      rut_v[acc_bank]   <= !match;
      rut_row[acc_bank] <= acc_row;
      rut_cnt[acc_bank] <= CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid  <= 1'b0;
      pre_valid <= 1'b0;
      keep_open <= 1'b0;
      cmd_bank  <= '0;
      cmd_row   <= '0;
    end else begin
      pf_valid  <= hit_fire || conf_fire;
      pre_valid <= hit_fire || conf_fire;
      keep_open <= miss && !match;
      cmd_bank  <= acc_bank;
      cmd_row   <= hit_fire ? rut_row[acc_bank] : acc_row;
    end
  end

  p_resp_needs_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid || keep_open) |-> $past(acc_valid && !acc_pfb));

  p_pfb_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_pfb) |-> (!pf_valid && !pre_valid && !keep_open));

  p_keep_only_on_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    keep_open |-> ($past(!acc_hit) && !pf_valid));

  p_ct_not_overfilled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ct_v == '1) |-> ($countones(ct_v) >= CT_DEPTH - 1));

  generate
    for (genvar g = 0; g < BANKS; g++) begin : g_cnt_chk
      p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rut_v[g] |-> (rut_cnt[g] >= CNT_W'(1) && rut_cnt[g] <= CNT_W'(THRESH)));
    end
    for (genvar k = 0; k < CT_DEPTH; k++) begin : g_age_chk
      p_age_dense_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ct_v[k] |-> (int'(ct_age[k]) < $countones(ct_v)));
    end
  endgenerate

endmodule

// File: tb/conflict_row_prefetcher_tb.sv
module conflict_row_prefetcher_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_hit = 1'b0, acc_pfb = 1'b0;
  logic [3:0] acc_bank = '0;
  logic [15:0] acc_row = '0;
  logic pf_valid, pre_valid, keep_open;
  logic [3:0] cmd_bank;
  logic [15:0] cmd_row;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  conflict_row_prefetcher u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_bank(acc_bank),
    .acc_row(acc_row), .acc_hit(acc_hit), .acc_pfb(acc_pfb),
    .pf_valid(pf_valid), .pre_valid(pre_valid), .keep_open(keep_open),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row));

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; acc_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic acc(input int b, input int r, input bit h, input bit p);
    acc_valid = 1'b1; acc_bank = 4'(b); acc_row = 16'(r); acc_hit = h; acc_pfb = p;
    @(negedge clk);
    acc_valid = 1'b0; acc_hit = 1'b0; acc_pfb = 1'b0;
  endtask

  task automatic chk(input string req, input bit epf, input bit ekeep, input int eb, input int er);
    bit bad;
    n_chk++;
    bad = (pf_valid !== epf) || (pre_valid !== epf) || (keep_open !== ekeep);
    if ((epf || ekeep) && (cmd_bank !== 4'(eb) || cmd_row !== 16'(er))) bad = 1'b1;
    if (bad) begin
      n_bad++;
      $display("FAIL %s: got pf=%0b pre=%0b keep=%0b bank=%0d row=%0d, expected pf=%0b pre=%0b keep=%0b bank=%0d row=%0d",
               req, pf_valid, pre_valid, keep_open, cmd_bank, cmd_row, epf, epf, ekeep, eb, er);
    end
  endtask

  task automatic t_reset_r1();
    do_reset();
    chk("R1 idle after reset", 0, 0, 0, 0);
    acc(3, 77, 0, 0); chk("R1 first miss keeps open", 0, 1, 3, 77);
  endtask

  task automatic t_idle_r10();
    do_reset();
    acc(1, 5, 0, 0); chk("R2 miss keep_open", 0, 1, 1, 5);
    @(negedge clk); chk("R10 pulse ends without access", 0, 0, 0, 0);
  endtask

  task automatic t_util_r3();
    do_reset();
    acc(2, 100, 0, 0);
    for (int k = 0; k < 3; k++) begin acc(2, 100, 1, 0); chk("R3 below threshold", 0, 0, 0, 0); end
    acc(2, 100, 1, 0); chk("R3 fifth access prefetches", 1, 0, 2, 100);
  endtask

  task automatic t_after_pf_r4();
    t_util_r3();
    acc(2, 100, 1, 0); chk("R4 hit after prefetch ignored", 0, 0, 0, 0);
    acc(2, 200, 0, 0); chk("R4 new row opens", 0, 1, 2, 200);
    acc(2, 100, 0, 0); chk("R4 prefetched row not in history", 0, 1, 2, 100);
  endtask

  task automatic t_conflict_r5_r6();
    do_reset();
    acc(4, 10, 0, 0); acc(4, 11, 0, 0);
    acc(4, 10, 0, 0); chk("R5 conflict prefetch", 1, 0, 4, 10);
    acc(4, 10, 1, 0); chk("R11 hit on empty bank ignored", 0, 0, 0, 0);
    acc(4, 10, 0, 0); chk("R6 entry removed after conflict prefetch", 0, 1, 4, 10);
  endtask

  task automatic t_bank_tag_r7();
    do_reset();
    acc(6, 33, 0, 0); acc(6, 34, 0, 0);
    acc(7, 33, 0, 0); chk("R7 other bank same row no match", 0, 1, 7, 33);
    acc(6, 33, 0, 0); chk("R7 own bank matches", 1, 0, 6, 33);
  endtask

  task automatic t_lru_r8();
    do_reset();
    for (int k = 0; k <= 33; k++) acc(5, 1000 + k, 0, 0);
    acc(5, 1000, 0, 0); chk("R8 oldest entry replaced", 0, 1, 5, 1000);
    acc(5, 1002, 0, 0); chk("R8 second oldest kept", 1, 0, 5, 1002);
  endtask

  task automatic t_pfb_r9();
    do_reset();
    acc(8, 50, 0, 0); acc(8, 51, 0, 0);
    acc(8, 50, 0, 1); chk("R9 pfb miss no output", 0, 0, 0, 0);
    acc(8, 52, 0, 0); chk("R9 history untouched by pfb", 0, 1, 8, 52);
    for (int k = 0; k < 3; k++) acc(8, 52, 1, 0);
    for (int k = 0; k < 5; k++) begin acc(8, 52, 1, 1); chk("R9 pfb hit no output", 0, 0, 0, 0); end
    acc(8, 52, 1, 0); chk("R9 count unchanged by pfb hits", 1, 0, 8, 52);
    acc(8, 50, 0, 0); chk("R9 earlier conflict still present", 1, 0, 8, 50);
  endtask

  initial begin
    fork
      begin
        t_reset_r1(); t_idle_r10(); t_util_r3(); t_after_pf_r4();
        t_conflict_r5_r6(); t_bank_tag_r7(); t_lru_r8(); t_pfb_r9();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog: got running, expected finished");
        end
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule